// File: doc/BRIEF.md
# Always-on rail power-up sequencer

This block takes a platform from fully unpowered to the standby state, where the always-on rails are up and the hub reset is released. It drives enables for a 5 V rail, a 3.3 V rail group and a 1.8 V rail. It also drives an active-low reset output to the platform controller hub. The 5 V rail and the chained 1.8 V / 1.05 V rails report through digital power-good pins. These pins are asynchronous, so each passes through a two-flop synchroniser. The 3.3 V group has no power-good pin. It is judged from a sampled millivolt reading, supplied with a valid strobe and an error strobe that are both synchronous to the clock.

A start request is accepted only in the off state. It proceeds only when the permission input is high at the same time. Each wait has a timeout. A wait that fails, an inhibited start, or a power-good that drops while in standby all lead to the same ordered shutdown. That shutdown asserts reset, holds a minimum gap, then removes the rails in the reverse of their power-up order. All delays are counted in clock cycles and derived from `CLK_HZ` and durations given in microseconds. A state output and a sticky fault code report progress and the cause of the last failure.

Top module: `aon_rail_seq`

## Requirements
- R1: After reset all three enables and `hub_rst_n` are low, `state_o` is 0 (off) and `fault_o` is 0. While `state_o` is 0, no enable and no `hub_rst_n` is high.
- R2: A start request with `pwr_ok` low sets `fault_o` to 3 (inhibit) and runs the shutdown sequence. No enable rises, and the block returns to `state_o` 0.
- R3: An accepted start raises `en_5v` one cycle later (`state_o` 1). `en_3v3` rises on the third clock edge after `pg_5v` goes high (`state_o` 2). `en_1v8` rises one edge after a valid ADC sample of at least `ADC_MIN_MV` (`state_o` 3). An enable is high only while every earlier rail's enable is high.
- R4: Once the synchronised `pg_1v8` and `pg_1v05` are both high, `state_o` becomes 4. The block stays in state 4 for exactly RST_DLY_US worth of cycles, then drives `hub_rst_n` high in `state_o` 5 (standby).
- R5: If no qualifying ADC sample arrives, state 2 is left after exactly ADC_TMO_US worth of cycles, with `fault_o` 1 (timeout), and shutdown runs.
- R6: An `adc_err` strobe in state 2 ends the wait at the next edge with `fault_o` 2 (ADC error). It takes precedence over a qualifying valid sample in the same cycle.
- R7: A digital power-good wait (state 1 or state 3) that is not met within PG_TMO_US worth of cycles sets `fault_o` 1, and shutdown runs.
- R8: Shutdown drives `hub_rst_n` low and holds `state_o` 6 for GAP_US worth of cycles. It then drops `en_1v8` (`state_o` 7), then `en_3v3` at the next edge (`state_o` 8), then `en_5v` at the next edge, returning to state 0.
- R9: In standby, losing any of the three power-good inputs starts shutdown three edges later and leaves `fault_o` unchanged.
- R10: A valid ADC sample below `ADC_MIN_MV` (for example 2999 against 3000) has no effect: `en_1v8` stays low and `state_o` stays 2.
- R11: `fault_o` holds its value through the off state and is cleared to 0 by the next accepted start.
- R12: `start_req` is ignored in every state other than off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req | input | 1 | Power-up request, synchronous |
| pwr_ok | input | 1 | Power-up permission, synchronous |
| pg_5v | input | 1 | 5 V power-good, asynchronous |
| pg_1v8 | input | 1 | 1.8 V power-good, asynchronous |
| pg_1v05 | input | 1 | 1.05 V power-good, asynchronous |
| adc_mv | input | ADC_W | 3.3 V reading in millivolts |
| adc_valid | input | 1 | `adc_mv` holds a new sample |
| adc_err | input | 1 | Conversion error strobe |
| en_5v | output | 1 | 5 V rail enable |
| en_3v3 | output | 1 | 3.3 V rail group enable |
| en_1v8 | output | 1 | 1.8 V rail enable |
| hub_rst_n | output | 1 | Active-low hub reset |
| state_o | output | 4 | Current state code (0 off ... 8) |
| fault_o | output | 2 | Sticky fault: 0 none, 1 timeout, 2 ADC error, 3 inhibit |

## Verification
The ADC error strobe and a valid sample above threshold can arrive in the same cycle of the 3.3 V wait, and only one of them can decide the exit. The bench drives both strobes together with a reading of exactly 3000 mV. It then expects the error path: fault code 2, `en_1v8` still low, and a shutdown that skips the 1.8 V rail. A second boundary is the reading one millivolt under threshold, which must leave the wait untouched.

// File: rtl/aon_rail_seq.sv
module aon_rail_seq #(
  parameter int CLK_HZ     = 100_000_000,
  parameter int PG_TMO_US  = 100_000,
  parameter int ADC_TMO_US = 1_000_000,
  parameter int RST_DLY_US = 10_000,
  parameter int GAP_US     = 1,
  parameter int ADC_W      = 12,
  parameter int ADC_MIN_MV = 3000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic             pwr_ok,
  input  logic             pg_5v,
  input  logic             pg_1v8,
  input  logic             pg_1v05,
  input  logic [ADC_W-1:0] adc_mv,
  input  logic             adc_valid,
  input  logic             adc_err,
  output logic             en_5v,
  output logic             en_3v3,
  output logic             en_1v8,
  output logic             hub_rst_n,
  output logic [3:0]       state_o,
  output logic [1:0]       fault_o
);
  localparam int CPU     = (CLK_HZ / 1_000_000 > 0) ? CLK_HZ / 1_000_000 : 1;
  localparam int PG_CYC  = CPU * PG_TMO_US;
  localparam int ADC_CYC = CPU * ADC_TMO_US;
  localparam int DLY_CYC = CPU * RST_DLY_US;
  localparam int GAP_CYC = CPU * GAP_US;
  localparam int MAXC01  = (PG_CYC > ADC_CYC) ? PG_CYC : ADC_CYC;
  localparam int MAXC23  = (DLY_CYC > GAP_CYC) ? DLY_CYC : GAP_CYC;
  localparam int MAXC    = (MAXC01 > MAXC23) ? MAXC01 : MAXC23;
  localparam int CW      = $clog2(MAXC + 1);

  localparam logic [1:0] F_NONE = 2'd0, F_TMO = 2'd1, F_ADC = 2'd2, F_INH = 2'd3;

  typedef enum logic [3:0] {
    S_OFF = 4'd0, S_W5 = 4'd1, S_W33 = 4'd2, S_W18 = 4'd3, S_DLY = 4'd4,
    S_STBY = 4'd5, S_GAP = 4'd6, S_D33 = 4'd7, S_D5 = 4'd8
  } st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [2:0]    pg_m, pg_s;

  wire pg5_s   = pg_s[0];
  wire pg_hi_s = pg_s[1] & pg_s[2];
  wire adc_ok  = adc_valid && (int'(adc_mv) >= ADC_MIN_MV);

  assign state_o = st;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pg_m <= '0;
      pg_s <= '0;
    end else begin
      pg_m <= {pg_1v05, pg_1v8, pg_5v};
      pg_s <= pg_m;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st        <= S_OFF;
      cnt       <= '0;
      en_5v     <= 1'b0;
      en_3v3    <= 1'b0;
      en_1v8    <= 1'b0;
      hub_rst_n <= 1'b0;
      fault_o   <= F_NONE;
    end else begin
      cnt <= cnt + 1'b1;
      case (st)
        S_OFF: begin
          cnt <= '0;
          if (start_req) begin
            if (pwr_ok) begin
              en_5v   <= 1'b1;
              fault_o <= F_NONE;
              st      <= S_W5;
            end else begin
              fault_o <= F_INH;
              st      <= S_GAP;
            end
          end
        end
        S_W5:
          if (pg5_s) begin
            en_3v3 <= 1'b1;
            cnt    <= '0;
            st     <= S_W33;
          end else if (int'(cnt) == PG_CYC - 1) begin
            fault_o <= F_TMO;
            cnt     <= '0;
            st      <= S_GAP;
          end
        S_W33:
          if (adc_err) begin
            fault_o <= F_ADC;
            cnt     <= '0;
            st      <= S_GAP;
          end else if (adc_ok) begin
            en_1v8 <= 1'b1;
            cnt    <= '0;
            st     <= S_W18;
          end else if (int'(cnt) == ADC_CYC - 1) begin
            fault_o <= F_TMO;
            cnt     <= '0;
            st      <= S_GAP;
          end
        S_W18:
          if (pg_hi_s) begin
            cnt <= '0;
            st  <= S_DLY;
          end else if (int'(cnt) == PG_CYC - 1) begin
            fault_o <= F_TMO;
            cnt     <= '0;
            st      <= S_GAP;
          end
        S_DLY:
          if (int'(cnt) == DLY_CYC - 1) begin
            hub_rst_n <= 1'b1;
            st        <= S_STBY;
          end
        S_STBY: begin
          cnt <= '0;
          if (!(pg5_s && pg_hi_s)) begin
            hub_rst_n <= 1'b0;
            st        <= S_GAP;
          end
        end
        S_GAP: begin
          hub_rst_n <= 1'b0;
          if (int'(cnt) == GAP_CYC - 1) begin
            en_1v8 <= 1'b0;
            st     <= S_D33;
          end
        end
        S_D33: begin
          en_3v3 <= 1'b0;
          st     <= S_D5;
        end
        S_D5: begin
          en_5v <= 1'b0;
          st    <= S_OFF;
        end
        default: st <= S_OFF;
      endcase
    end
endmodule

module aon_rail_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en_5v,
  input logic       en_3v3,
  input logic       en_1v8,
  input logic       hub_rst_n,
  input logic [3:0] state_o,
  input logic [1:0] fault_o
);
  p_off_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 4'd0) |-> (!en_5v && !en_3v3 && !en_1v8 && !hub_rst_n));
  p_rail_chain_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_1v8 |-> en_3v3) and (en_3v3 |-> en_5v));
  p_rst_after_rails_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hub_rst_n |-> (en_5v && en_3v3 && en_1v8));
  p_gap_before_1v8_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_1v8) |-> (!hub_rst_n && $past(!hub_rst_n)));
  p_5v_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_5v) |-> (!en_3v3 && !en_1v8));
  p_clean_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hub_rst_n) |-> (fault_o == 2'd0));
endmodule

bind aon_rail_seq aon_rail_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .en_5v(en_5v), .en_3v3(en_3v3), .en_1v8(en_1v8),
  .hub_rst_n(hub_rst_n), .state_o(state_o), .fault_o(fault_o)
);

// File: tb/aon_rail_seq_tb.sv
module aon_rail_seq_tb_top;
  localparam int PG_T = 50, ADC_T = 80, DLY_T = 30, GAP_T = 4;

  logic clk = 0, rst_n = 0;
  logic start_req = 0, pwr_ok = 0, pg_5v = 0, pg_1v8 = 0, pg_1v05 = 0;
  logic [11:0] adc_mv = 0;
  logic adc_valid = 0, adc_err = 0;
  logic en_5v, en_3v3, en_1v8, hub_rst_n;
  logic [3:0] state_o;
  logic [1:0] fault_o;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  aon_rail_seq #(.CLK_HZ(1_000_000), .PG_TMO_US(PG_T), .ADC_TMO_US(ADC_T),
                 .RST_DLY_US(DLY_T), .GAP_US(GAP_T), .ADC_W(12), .ADC_MIN_MV(3000)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .pwr_ok(pwr_ok),
    .pg_5v(pg_5v), .pg_1v8(pg_1v8), .pg_1v05(pg_1v05), .adc_mv(adc_mv),
    .adc_valid(adc_valid), .adc_err(adc_err), .en_5v(en_5v), .en_3v3(en_3v3),
    .en_1v8(en_1v8), .hub_rst_n(hub_rst_n), .state_o(state_o), .fault_o(fault_o));

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_st(int s);
    for (int i = 0; i < 400 && state_o != s; i++) @(negedge clk);
  endtask

  task automatic count_in(int s, output int n);
    n = 0;
    while (state_o == s && n < 2000) begin n++; @(negedge clk); end
  endtask

  task automatic pulse_start(logic ok);
    pwr_ok = ok; start_req = 1;
    @(negedge clk); start_req = 0;
  endtask

  task automatic sd_check(string req, bit h5, bit h33);
    int n;
    wait_st(6);
    check({req, " reset low in gap"}, hub_rst_n, 0);
    count_in(6, n);
    check({req, " R8 gap cycles"}, n, GAP_T);
    check({req, " R8 state after gap"}, state_o, 7);
    check({req, " R8 1v8 off first"}, {en_1v8, en_3v3, en_5v}, {1'b0, h33, h5});
    @(negedge clk);
    check({req, " R8 3v3 off second"}, {state_o, en_3v3, en_5v}, {4'd8, 1'b0, h5});
    @(negedge clk);
    check({req, " R8 5v off last"}, {state_o, en_5v}, {4'd0, 1'b0});
    pg_5v = 0; pg_1v8 = 0; pg_1v05 = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic to_w33();
    pulse_start(1);
    check("R3 5v on after start", {state_o, en_5v, en_3v3}, {4'd1, 1'b1, 1'b0});
    check("R11 fault cleared by start", fault_o, 0);
    pg_5v = 1;
    repeat (2) @(negedge clk);
    check("R3 3v3 not before sync", en_3v3, 0);
    @(negedge clk);
    check("R3 3v3 on third edge", {state_o, en_3v3}, {4'd2, 1'b1});
  endtask

  task automatic to_standby();
    int n;
    to_w33();
    adc_valid = 1; adc_mv = 2999;
    @(negedge clk); adc_valid = 0;
    check("R10 below threshold ignored", {state_o, en_1v8}, {4'd2, 1'b0});
    adc_valid = 1; adc_mv = 3000;
    @(negedge clk); adc_valid = 0;
    check("R3 1v8 on at threshold", {state_o, en_1v8}, {4'd3, 1'b1});
    pg_1v8 = 1; pg_1v05 = 1;
    repeat (3) @(negedge clk);
    check("R4 delay entered", state_o, 4);
    count_in(4, n);
    check("R4 delay length", n, DLY_T);
    check("R4 reset released in standby", {state_o, hub_rst_n}, {4'd5, 1'b1});
  endtask

  task automatic t_reset();
    check("R1 reset outputs", {en_5v, en_3v3, en_1v8, hub_rst_n, state_o, fault_o}, 0);
  endtask

  task automatic t_inhibit();
    pulse_start(0);
    check("R2 inhibit fault", fault_o, 3);
    check("R2 no 5v", en_5v, 0);
    sd_check("R2", 0, 0);
    check("R11 fault held in off", fault_o, 3);
  endtask

  task automatic t_full_and_loss();
    to_standby();
    pulse_start(1);
    check("R12 start ignored in standby", {state_o, hub_rst_n}, {4'd5, 1'b1});
    pg_1v05 = 0;
    repeat (2) @(negedge clk);
    check("R9 still standby during sync", state_o, 5);
    @(negedge clk);
    check("R9 shutdown after pg loss", {state_o, hub_rst_n}, {4'd6, 1'b0});
    check("R9 fault unchanged", fault_o, 0);
    sd_check("R9", 1, 1);
  endtask

  task automatic t_adc_timeout();
    int n;
    to_w33();
    pulse_start(1);
    n = 1;
    while (state_o == 2 && n < 2000) begin n++; @(negedge clk); end
    check("R5 adc timeout cycles", n, ADC_T);
    check("R5 timeout fault", fault_o, 1);
    sd_check("R5", 1, 1);
  endtask

  task automatic t_adc_err_collision();
    to_w33();
    adc_valid = 1; adc_err = 1; adc_mv = 3000;
    @(negedge clk); adc_valid = 0; adc_err = 0;
    check("R6 error wins over valid", {state_o, en_1v8, fault_o}, {4'd6, 1'b0, 2'd2});
    sd_check("R6", 1, 1);
  endtask

  task automatic t_pg_timeouts();
    int n;
    pulse_start(1);
    count_in(1, n);
    check("R7 5v pg timeout cycles", n, PG_T);
    check("R7 5v timeout fault", fault_o, 1);
    sd_check("R7 w5", 1, 0);
    to_w33();
    adc_valid = 1; adc_mv = 3300;
    @(negedge clk); adc_valid = 0;
    pg_1v8 = 1;
    count_in(3, n);
    check("R7 1v8 pg timeout cycles", n, PG_T);
    check("R7 1v8 timeout fault", fault_o, 1);
    sd_check("R7 w18", 1, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_inhibit();
    t_full_and_loss();
    t_adc_timeout();
    t_adc_err_collision();
    t_pg_timeouts();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule